// File: doc/BRIEF.md
# Soft-Start Ramp and Power-Good Sequencer

This block sequences the start-up of a switching regulator in the digital domain. Once the supply is above its lockout level and the enable input is high, it waits for the feedback pin check to report a healthy pin. Only then does it release a soft-start reference ramp. The ramp is a counter that advances by one code on each switching-clock strobe. A code of 3200 equals the regulation reference, and the ramp stops at 4000, which is 125% of that level.

Along the way the block gives two milestone permits. At 95% of the reference (code 3040) it allows full synchronous rectification. At 4000 it turns on fault enable, and only from that point may the power-good output be released. Power-good follows two window comparator flags (feedback too low, feedback too high). Each flag passes through a two-flop synchronizer before it is used. Dropping enable or the supply clears the ramp and the whole sequence, and a restart begins again from the pin check.

The analog ramp, the error amplifier and the modulator lie outside this block. The comparators reach it only as digital flags.

Top module: `ramp_sequencer`

## Requirements
- R1: While the synchronous active-low reset rstN is low at a clock edge, every output is 0 after that edge: rampCode, syncRectOk, faultEnable and pgoodRelease.
- R2: rampCode stays 0 until supplyOk and enable are both high and fbPinOk has been seen high. Strobes on swTick before that have no effect.
- R3: Once released, rampCode increases by exactly one at each clock edge where swTick is 1, and it holds its value at edges where swTick is 0.
- R4: rampCode equals the reference code 3200 after exactly 3200 swTick strobes counted from release.
- R5: syncRectOk is 1 exactly when rampCode is at least 3040 (95% of the reference), and it is 0 at 3039.
- R6: faultEnable becomes 1 when rampCode reaches 4000 (125% of the reference). Further strobes leave rampCode at 4000.
- R7: pgoodRelease is 0 whenever faultEnable is 0, even when both window flags show the feedback inside the window.
- R8: With faultEnable at 1, pgoodRelease is 1 only when both fbLowFlag and fbHighFlag are 0. A change on either flag reaches pgoodRelease after the second clock edge that follows it, and not after the first.
- R9: A clock edge that sees supplyOk or enable low clears rampCode, syncRectOk, faultEnable and pgoodRelease. The next start waits again for fbPinOk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| swTick | input | 1 | One-cycle strobe per switching clock period |
| supplyOk | input | 1 | Bias supply above its lockout level |
| enable | input | 1 | Regulator enable |
| fbPinOk | input | 1 | Feedback pin found neither open nor shorted |
| fbLowFlag | input | 1 | Asynchronous flag: feedback below the lower window edge (-11%) |
| fbHighFlag | input | 1 | Asynchronous flag: feedback above the upper window edge (+10%) |
| rampCode | output | 12 | Soft-start reference code (3200 = reference) |
| syncRectOk | output | 1 | Full synchronous rectification permitted |
| faultEnable | output | 1 | Fault latch armed |
| pgoodRelease | output | 1 | 1 releases the open-drain power-good pin, 0 pulls it low |

## Verification
The ramp is driven three ways: with strobes on every cycle, with strobes spaced by idle cycles, and with strobes sent while the start conditions are missing. Together these separate counting of switching clocks from counting of system clocks, and show that the ramp is gated before release. The milestone codes are checked on both sides of their thresholds (3039/3040, 3999/4000), and strobes past 4000 show that the ramp saturates. All four combinations of the window flags are walked once fault enable is on, and a single flag change is timed edge by edge to show the synchronizer delay. Enable and supply are each dropped mid-sequence to show that a restart needs the pin check again.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    SQ_OFF,
    SQ_PINCHK,
    SQ_RAMP,
    SQ_HOLD
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } seqStrobe_t;

  function automatic int pctOf(input int base, input int pct);
    return (base * pct) / 100;
  endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gRest
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swTick,
  input  logic       supplyOk,
  input  logic       enable,
  input  logic       fbPinOk,
  input  logic       atTop,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;
  logic      runOk;

  assign runOk = supplyOk && enable;

  always_comb begin
    stateNext = state;
    if (!runOk) begin
      stateNext = SQ_OFF;
    end else begin
      unique case (state)
        SQ_OFF:    stateNext = SQ_PINCHK;
        SQ_PINCHK: if (fbPinOk) stateNext = SQ_RAMP;
        SQ_RAMP:   if (atTop)   stateNext = SQ_HOLD;
        SQ_HOLD:   stateNext = SQ_HOLD;
        default:   stateNext = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SQ_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clr = !runOk || (state == SQ_OFF);
    strobe.inc = runOk && (state == SQ_RAMP) && swTick;
  end

endmodule

// File: rtl/rseq_datapath.sv
module rseq_datapath
  import rseq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int REF_COUNT   = 3200,
  parameter int SR_PCT      = 95,
  parameter int FE_PCT      = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             fbLowFlag,
  input  logic             fbHighFlag,
  output logic [CNT_W-1:0] rampCode,
  output logic             atTop,
  output logic             syncRectOk,
  output logic             faultEnable,
  output logic             pgoodRelease
);

  localparam logic [CNT_W-1:0] SR_CODE = CNT_W'(pctOf(REF_COUNT, SR_PCT));
  localparam logic [CNT_W-1:0] FE_CODE = CNT_W'(pctOf(REF_COUNT, FE_PCT));

  logic [CNT_W-1:0] rampCnt;
  logic [1:0]       flagSync;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) begin
      rampCnt <= '0;
    end else if (strobe.inc && !atTop) begin
      rampCnt <= rampCnt + 1'b1;
    end
  end

  rseq_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES)
  ) u_flagSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({fbHighFlag, fbLowFlag}),
    .dout (flagSync)
  );

  assign rampCode     = rampCnt;
  assign atTop        = (rampCnt == FE_CODE);
  assign syncRectOk   = (rampCnt >= SR_CODE);
  assign faultEnable  = atTop;
  assign pgoodRelease = atTop && (flagSync == 2'b00);

endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
  import rseq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int REF_COUNT   = 3200,
  parameter int SR_PCT      = 95,
  parameter int FE_PCT      = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swTick,
  input  logic             supplyOk,
  input  logic             enable,
  input  logic             fbPinOk,
  input  logic             fbLowFlag,
  input  logic             fbHighFlag,
  output logic [CNT_W-1:0] rampCode,
  output logic             syncRectOk,
  output logic             faultEnable,
  output logic             pgoodRelease
);

  seqStrobe_t strobe;
  logic       atTop;

  rseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swTick   (swTick),
    .supplyOk (supplyOk),
    .enable   (enable),
    .fbPinOk  (fbPinOk),
    .atTop    (atTop),
    .strobe   (strobe)
  );

  rseq_datapath #(
    .CNT_W       (CNT_W),
    .REF_COUNT   (REF_COUNT),
    .SR_PCT      (SR_PCT),
    .FE_PCT      (FE_PCT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fbLowFlag    (fbLowFlag),
    .fbHighFlag   (fbHighFlag),
    .rampCode     (rampCode),
    .atTop        (atTop),
    .syncRectOk   (syncRectOk),
    .faultEnable  (faultEnable),
    .pgoodRelease (pgoodRelease)
  );

endmodule

// File: rtl/rseq_checker.sv
module rseq_checker #(
  parameter int CNT_W     = 12,
  parameter int REF_COUNT = 3200,
  parameter int FE_PCT    = 125
) (
  input logic             clk,
  input logic             rstN,
  input logic             swTick,
  input logic             supplyOk,
  input logic             enable,
  input logic [CNT_W-1:0] rampCode,
  input logic             syncRectOk,
  input logic             faultEnable,
  input logic             pgoodRelease
);

  localparam logic [CNT_W-1:0] TOP_CODE = CNT_W'((REF_COUNT * FE_PCT) / 100);

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rampCode == $past(rampCode)) || (rampCode == $past(rampCode) + 1'b1) || (rampCode == '0)); // R3

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !swTick |=> $stable(rampCode) || (rampCode == '0)); // R3

  AST_RAMP_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    rampCode <= TOP_CODE); // R6

  AST_TOP_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultEnable) |-> (rampCode == TOP_CODE)); // R6

  AST_FE_AFTER_SR: assert property (@(posedge clk) disable iff (!rstN)
    faultEnable |-> syncRectOk); // R5

  AST_PG_NEEDS_FE: assert property (@(posedge clk) disable iff (!rstN)
    pgoodRelease |-> faultEnable); // R7

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !(supplyOk && enable) |=> (rampCode == '0) && !syncRectOk && !faultEnable && !pgoodRelease); // R9

endmodule

bind ramp_sequencer rseq_checker #(
  .CNT_W     (CNT_W),
  .REF_COUNT (REF_COUNT),
  .FE_PCT    (FE_PCT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .swTick       (swTick),
  .supplyOk     (supplyOk),
  .enable       (enable),
  .rampCode     (rampCode),
  .syncRectOk   (syncRectOk),
  .faultEnable  (faultEnable),
  .pgoodRelease (pgoodRelease)
);

// File: tb/ramp_sequencer_tb.sv
module ramp_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN, swTick, supplyOk, enable, fbPinOk, fbLowFlag, fbHighFlag;
  logic [11:0] rampCode;
  logic        syncRectOk, faultEnable, pgoodRelease;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // {fbLowFlag, fbHighFlag, expected pgoodRelease}
  localparam logic [2:0] PG_VEC [5] = '{3'b001, 3'b100, 3'b010, 3'b110, 3'b001};

  always #5 clk = ~clk;

  ramp_sequencer u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .swTick       (swTick),
    .supplyOk     (supplyOk),
    .enable       (enable),
    .fbPinOk      (fbPinOk),
    .fbLowFlag    (fbLowFlag),
    .fbHighFlag   (fbHighFlag),
    .rampCode     (rampCode),
    .syncRectOk   (syncRectOk),
    .faultEnable  (faultEnable),
    .pgoodRelease (pgoodRelease)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input int code, input int sr, input int fe, input int pg);
    check({req, " rampCode"}, int'(rampCode), code);
    check({req, " syncRectOk"}, int'(syncRectOk), sr);
    check({req, " faultEnable"}, int'(faultEnable), fe);
    check({req, " pgoodRelease"}, int'(pgoodRelease), pg);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      swTick = 1'b1;
    end
    @(negedge clk);
    swTick = 1'b0;
  endtask

  task automatic gapTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      swTick = 1'b1;
      @(negedge clk);
      swTick = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; swTick = 1'b1; supplyOk = 1'b1; enable = 1'b1;
    fbPinOk = 1'b1; fbLowFlag = 1'b0; fbHighFlag = 1'b0;
    waitCycles(4);
    checkAll("R1 reset", 0, 0, 0, 0);

    // R2: pin check failing, strobes present
    swTick = 1'b0; fbPinOk = 1'b0;
    rstN = 1'b1;
    doTicks(20);
    check("R2 pin not ok", int'(rampCode), 0);

    // R2: supply low, pin fine
    supplyOk = 1'b0; fbPinOk = 1'b1;
    doTicks(10);
    check("R2 supply low", int'(rampCode), 0);

    // release: edge 1 -> pin check, edge 2 -> ramping
    supplyOk = 1'b1;
    waitCycles(2);
    check("R2 released, no tick yet", int'(rampCode), 0);

    gapTicks(100);
    check("R3 spaced strobes", int'(rampCode), 100);
    waitCycles(5);
    check("R3 idle cycles hold", int'(rampCode), 100);

    doTicks(2939);
    check("R5 code", int'(rampCode), 3039);
    check("R5 below 95%", int'(syncRectOk), 0);
    doTicks(1);
    check("R5 at 95%", int'(syncRectOk), 1);

    doTicks(160);
    check("R4 reference reached", int'(rampCode), 3200);
    check("R6 not yet armed", int'(faultEnable), 0);

    doTicks(799);
    check("R6 code 3999", int'(rampCode), 3999);
    check("R6 not armed at 3999", int'(faultEnable), 0);
    check("R7 pgood held low before arm", int'(pgoodRelease), 0);

    doTicks(1);
    checkAll("R6 armed", 4000, 1, 1, 1);
    doTicks(10);
    check("R6 saturated", int'(rampCode), 4000);

    // R8: window flag combinations
    for (int v = 0; v < 5; v++) begin
      @(negedge clk);
      fbLowFlag  = PG_VEC[v][2];
      fbHighFlag = PG_VEC[v][1];
      waitCycles(3);
      check($sformatf("R8 vector %0d", v), int'(pgoodRelease), int'(PG_VEC[v][0]));
    end

    // R8: synchronizer latency
    @(negedge clk);
    fbHighFlag = 1'b1;
    @(negedge clk);
    check("R8 one edge later", int'(pgoodRelease), 1);
    @(negedge clk);
    check("R8 two edges later", int'(pgoodRelease), 0);
    fbHighFlag = 1'b0;
    waitCycles(3);

    // R9: enable toggle
    enable = 1'b0;
    @(negedge clk);
    checkAll("R9 enable drop", 0, 0, 0, 0);
    enable = 1'b1; fbPinOk = 1'b0;
    doTicks(10);
    check("R9 restart waits for pin", int'(rampCode), 0);
    fbPinOk = 1'b1;
    waitCycles(2);
    doTicks(5);
    check("R9 restarted ramp", int'(rampCode), 5);

    supplyOk = 1'b0;
    @(negedge clk);
    check("R9 supply drop", int'(rampCode), 0);
    supplyOk = 1'b1;
    waitCycles(2);
    doTicks(7);
    check("R3 ramp after supply return", int'(rampCode), 7);

    // R1: reset mid-ramp
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1 reset mid-ramp", 0, 0, 0, 0);
    rstN = 1'b1;
    waitCycles(2);

    finishRun();
  end

endmodule